// File: doc/BRIEF.md
# Ratioed Clock Crossing Enable Generator

This block moves data between a fast clock and a slow clock that come from the same PLL, where the slow period is a fractional multiple of the fast period. Because the two clocks keep a fixed periodic relationship, the crossing uses no metastability synchronizers. Instead, a single fast-domain enable pulse marks the one fast cycle per slow period in which data may cross. That one enable qualifies both directions: fast-to-slow and slow-to-fast.

The ratio is programmed as a count of quarter fast periods, from 8 (ratio 2.0) to 21 (ratio 5.25). A phase accumulator in the fast domain advances by four quarters every fast cycle and wraps at the programmed count. From it, the block places the enable on the fast edge nearest the middle of each slow period. This leaves about half a slow period of setup margin and about half of hold margin at the receiving edge, in both directions.

The block also includes the registers on each side of both crossings. On the fast side these are a transmit holding register and a receive capture register with a valid strobe. On the slow side they are a launch register and a capture register.

Reset is synchronous and active high in both domains. It must be released so that the first slow rising edge out of reset coincides with a fast rising edge, which is the common alignment point of the two PLL outputs. The fast side detects that edge through a toggle marker kept in the slow domain. The enable stays off until this detection has happened.

Top module: `ratioed_xing_enable`

## Requirements
- R1: `ratio_qtr` is an unsigned 5-bit count of quarter fast periods per slow period. Codes below 8 behave exactly like 8, and codes above 21 behave exactly like 21.
- R2: `sync_en` is low during reset. After reset it stays low until the first slow rising edge has been detected. Its earliest high cycle is the fast cycle that ends two fast edges after that slow edge.
- R3: Once enabled, `sync_en` is high for exactly one fast cycle in every slow period and is never high in two consecutive fast cycles.
- R4: Let q be the effective quarter count and w = floor(q/2) - 2. The fast rising edge that ends an enable cycle lies between w and w+3 quarters (inclusive) after the slow rising edge that precedes it. One quarter is a quarter of a fast period.
- R5: The fast holding register loads `fast_tx_data` only at the end of an enable cycle and holds its value otherwise. `slow_rx_data` shows the held word from the next slow rising edge onward.
- R6: The slow launch register loads `slow_tx_data` on every slow rising edge. `fast_rx_data` captures that word only at the end of an enable cycle. `fast_rx_valid` is high for exactly the fast cycle after each capture.
- R7: After reset, `fast_rx_data`, `fast_rx_valid`, `slow_rx_data` and both transmit-side registers are zero.
- R8: At every legal ratio, each slow-period word reaches the fast side once, in order, with no gap or repeat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock |
| clk_slow | input | 1 | Slow clock, rising edges every q quarters of the fast period |
| rst | input | 1 | Synchronous active-high reset for both domains |
| ratio_qtr | input | 5 | Slow period in quarter fast periods (8 to 21, clamped) |
| fast_tx_data | input | DATA_W | Word offered by the fast side for the slow side |
| slow_tx_data | input | DATA_W | Word offered by the slow side for the fast side |
| sync_en | output | 1 | Crossing enable, fast domain, one cycle per slow period |
| slow_rx_data | output | DATA_W | Word received in the slow domain |
| fast_rx_data | output | DATA_W | Word received in the fast domain |
| fast_rx_valid | output | 1 | High in the fast cycle after each capture into `fast_rx_data` |

## Verification
The bench builds the block with its default 16-bit data width. It runs every quarter code from 8 to 21, plus one code below the legal range and one above it, and each run gets a fresh reset that lands on a coincident edge. The fast clock has a 4 ns period, so one quarter is exactly 1 ns and the slow clock period equals the quarter code in nanoseconds. This lets the bench compute every enable position, every captured word and every margin window with integer arithmetic on simulation time. Each run covers 24 slow periods, which passes through every fractional phase the accumulator can take at that ratio.

// File: rtl/rcx_pkg.sv
`timescale 1ns/100ps
package rcx_pkg;
    localparam int QCODE_W      = 5;
    localparam int QTR_MIN      = 8;
    localparam int QTR_MAX      = 21;
    localparam int QTR_PER_FAST = 4;
    localparam int WIN_HALF     = QTR_PER_FAST / 2;

    typedef logic [QCODE_W-1:0] qtr_t;

    typedef struct packed {
        logic locked;
        qtr_t phase;
        logic en;
    } phase_t;

    function automatic qtr_t clamp_qtr(qtr_t code);
        if (code < qtr_t'(QTR_MIN)) return qtr_t'(QTR_MIN);
        if (code > qtr_t'(QTR_MAX)) return qtr_t'(QTR_MAX);
        return code;
    endfunction

    function automatic qtr_t step_phase(qtr_t ph, qtr_t q, qtr_t inc);
        logic [QCODE_W:0] s;
        s = {1'b0, ph} + {1'b0, inc};
        if (s >= {1'b0, q}) s = s - {1'b0, q};
        return s[QCODE_W-1:0];
    endfunction

    function automatic logic in_window(qtr_t ph, qtr_t q);
        qtr_t lo;
        lo = (q >> 1) - qtr_t'(WIN_HALF);
        return (ph >= lo) && (ph < lo + qtr_t'(QTR_PER_FAST));
    endfunction

    function automatic qtr_t gap_short(qtr_t q);
        return q >> 2;
    endfunction

    function automatic qtr_t gap_long(qtr_t q);
        return (q + qtr_t'(3)) >> 2;
    endfunction
endpackage

// File: rtl/rcx_phase_gen.sv
`timescale 1ns/100ps
module rcx_phase_gen
    import rcx_pkg::*;
(
    input  logic clk_fast,
    input  logic rst,
    input  qtr_t ratio_qtr,
    input  logic slow_mark,
    output logic sync_en
);
    qtr_t   q_eff;
    phase_t cur, nxt;
    logic   mark_q;

    assign q_eff = clamp_qtr(ratio_qtr);

    always_comb begin
        nxt = cur;
        if (!cur.locked) begin
            nxt.en = 1'b0;
            if (slow_mark != mark_q) begin
                nxt.locked = 1'b1;
                nxt.phase  = step_phase(qtr_t'(QTR_PER_FAST), q_eff, qtr_t'(QTR_PER_FAST));
                nxt.en     = in_window(nxt.phase, q_eff);
            end
        end else begin
            nxt.phase = step_phase(cur.phase, q_eff, qtr_t'(QTR_PER_FAST));
            nxt.en    = in_window(nxt.phase, q_eff);
        end
    end

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            cur    <= '0;
            mark_q <= 1'b0;
        end else begin
            cur    <= nxt;
            mark_q <= slow_mark;
        end
    end

    assign sync_en = cur.en;

    // spacing observer for the enable pulses
    qtr_t gap;
    logic had_en;
    always_ff @(posedge clk_fast) begin
        if (rst) begin
            gap    <= '0;
            had_en <= 1'b0;
        end else if (cur.en) begin
            gap    <= qtr_t'(1);
            had_en <= 1'b1;
        end else if (gap != '1) begin
            gap <= gap + qtr_t'(1);
        end
    end

    p_qtr_legal_r1: assert property (@(posedge clk_fast) disable iff (rst)
        (q_eff >= qtr_t'(QTR_MIN)) && (q_eff <= qtr_t'(QTR_MAX)));

    p_quiet_until_locked_r2: assert property (@(posedge clk_fast) disable iff (rst)
        !cur.locked |-> !sync_en);

    p_single_cycle_r3: assert property (@(posedge clk_fast) disable iff (rst)
        sync_en |=> !sync_en);

    p_pulse_spacing_r3: assert property (@(posedge clk_fast) disable iff (rst)
        (sync_en && had_en) |-> (gap == gap_short(q_eff) || gap == gap_long(q_eff)));

    p_phase_range_r4: assert property (@(posedge clk_fast) disable iff (rst)
        cur.locked |-> (cur.phase < q_eff));
endmodule

// File: rtl/rcx_fast_port.sv
`timescale 1ns/100ps
module rcx_fast_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic              sync_en,
    input  logic [DATA_W-1:0] tx_in,
    input  logic [DATA_W-1:0] launch_from_slow,
    output logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] rx_q,
    output logic              rx_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] rx;
        logic              valid;
    } fast_regs_t;

    fast_regs_t r;

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            r <= '0;
        end else begin
            if (sync_en) begin
                r.hold <= tx_in;
                r.rx   <= launch_from_slow;
            end
            r.valid <= sync_en;
        end
    end

    assign hold_q   = r.hold;
    assign rx_q     = r.rx;
    assign rx_valid = r.valid;

    p_hold_stable_r5: assert property (@(posedge clk_fast) disable iff (rst)
        !sync_en |=> $stable(hold_q));

    p_rx_stable_r6: assert property (@(posedge clk_fast) disable iff (rst)
        !sync_en |=> $stable(rx_q));

    p_valid_once_r6: assert property (@(posedge clk_fast) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/rcx_slow_port.sv
`timescale 1ns/100ps
module rcx_slow_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk_slow,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_in,
    input  logic [DATA_W-1:0] hold_from_fast,
    output logic [DATA_W-1:0] launch_q,
    output logic [DATA_W-1:0] rx_q,
    output logic              edge_mark
);
    typedef struct packed {
        logic [DATA_W-1:0] launch;
        logic [DATA_W-1:0] rx;
        logic              mark;
    } slow_regs_t;

    slow_regs_t r;

    always_ff @(posedge clk_slow) begin
        if (rst) begin
            r <= '0;
        end else begin
            r.launch <= tx_in;
            r.rx     <= hold_from_fast;
            r.mark   <= ~r.mark;
        end
    end

    assign launch_q  = r.launch;
    assign rx_q      = r.rx;
    assign edge_mark = r.mark;

    p_mark_toggles_r2: assert property (@(posedge clk_slow) disable iff (rst)
        !rst |=> (edge_mark != $past(edge_mark)));
endmodule

// File: rtl/ratioed_xing_enable.sv
`timescale 1ns/100ps
module ratioed_xing_enable
    import rcx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk_fast,
    input  logic               clk_slow,
    input  logic               rst,
    input  logic [QCODE_W-1:0] ratio_qtr,
    input  logic [DATA_W-1:0]  fast_tx_data,
    input  logic [DATA_W-1:0]  slow_tx_data,
    output logic               sync_en,
    output logic [DATA_W-1:0]  slow_rx_data,
    output logic [DATA_W-1:0]  fast_rx_data,
    output logic               fast_rx_valid
);
    logic              slow_mark;
    logic [DATA_W-1:0] fast_hold;
    logic [DATA_W-1:0] slow_launch;

    rcx_phase_gen u_phase (
        .clk_fast  (clk_fast),
        .rst       (rst),
        .ratio_qtr (ratio_qtr),
        .slow_mark (slow_mark),
        .sync_en   (sync_en)
    );

    rcx_fast_port #(.DATA_W(DATA_W)) u_fast (
        .clk_fast         (clk_fast),
        .rst              (rst),
        .sync_en          (sync_en),
        .tx_in            (fast_tx_data),
        .launch_from_slow (slow_launch),
        .hold_q           (fast_hold),
        .rx_q             (fast_rx_data),
        .rx_valid         (fast_rx_valid)
    );

    rcx_slow_port #(.DATA_W(DATA_W)) u_slow (
        .clk_slow       (clk_slow),
        .rst            (rst),
        .tx_in          (slow_tx_data),
        .hold_from_fast (fast_hold),
        .launch_q       (slow_launch),
        .rx_q           (slow_rx_data),
        .edge_mark      (slow_mark)
    );
endmodule

// File: tb/tb_ratioed_xing_enable.sv
`timescale 1ns/100ps
module tb_ratioed_xing_enable;
    localparam int W = 16;

    logic         clk_fast = 1'b1;
    logic         clk_slow = 1'b0;
    logic         rst = 1'b1;
    logic [4:0]   ratio_qtr = 5'd8;
    logic [W-1:0] fast_tx_data = '0;
    logic [W-1:0] slow_tx_data = '0;
    logic         sync_en;
    logic [W-1:0] slow_rx_data;
    logic [W-1:0] fast_rx_data;
    logic         fast_rx_valid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    ratioed_xing_enable #(.DATA_W(W)) dut (
        .clk_fast      (clk_fast),
        .clk_slow      (clk_slow),
        .rst           (rst),
        .ratio_qtr     (ratio_qtr),
        .fast_tx_data  (fast_tx_data),
        .slow_tx_data  (slow_tx_data),
        .sync_en       (sync_en),
        .slow_rx_data  (slow_rx_data),
        .fast_rx_data  (fast_rx_data),
        .fast_rx_valid (fast_rx_valid)
    );

    // 250 MHz: rising edges at multiples of 4 ns, so one quarter = 1 ns
    initial forever begin
        #2 clk_fast = 1'b0;
        #2 clk_fast = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit en_at(input int e, input int t0, input int q);
        int w;
        int ph;
        w = q / 2 - 2;
        if (e < t0 + 8) return 1'b0;
        ph = (e - t0) % q;
        return (ph >= w) && (ph < w + 4);
    endfunction

    task automatic run_ratio(input logic [4:0] code, input int q, input int nper, input string note);
        int bt;
        int t0;
        int stop_t;
        int w;
        @(negedge clk_fast);
        rst = 1'b1;
        ratio_qtr = code;
        fast_tx_data = '0;
        slow_tx_data = '0;
        w = q / 2 - 2;
        bt = (int'($time) / (4 * q) + 1) * (4 * q);
        t0 = bt + 4 * q;
        stop_t = t0 + nper * q;
        fork
            begin : slow_gen
                #(bt - int'($time));
                for (int k = 0; k < nper + 6; k++) begin
                    clk_slow = 1'b1;
                    #(q / 2.0);
                    clk_slow = 1'b0;
                    #(q - q / 2.0);
                end
            end
            begin : rst_ctl
                #(t0 - 2 - int'($time));
                rst = 1'b0;
            end
            begin : fast_side
                int last_word;
                last_word = -1;
                while (int'($time) + 4 <= stop_t) begin
                    int n;
                    int e;
                    int ep;
                    bit exp_en;
                    bit exp_v;
                    #4;
                    n = int'($time);
                    e = n + 2;
                    ep = n - 2;
                    fast_tx_data = W'(e / 4);
                    exp_en = en_at(e, t0, q);
                    exp_v = en_at(ep, t0, q);
                    if (e <= t0) begin
                        check(sync_en == 1'b0, {note, " R2 enable low before lock"}, sync_en, 0);
                        check(fast_rx_valid == 1'b0 && fast_rx_data == '0,
                              {note, " R7 fast receive reset state"}, fast_rx_data, 0);
                    end else begin
                        check(sync_en == exp_en, {note, " R3 R4 enable position"}, sync_en, exp_en);
                        check(fast_rx_valid == exp_v, {note, " R6 valid strobe"}, fast_rx_valid, exp_v);
                        if (exp_v) begin
                            int k;
                            k = (ep - t0) / q;
                            check(fast_rx_data == W'(k), {note, " R6 slow-to-fast word"},
                                  fast_rx_data, k);
                            if (last_word >= 0)
                                check(int'(fast_rx_data) == last_word + 1,
                                      {note, " R8 in-order delivery"}, fast_rx_data, last_word + 1);
                            last_word = int'(fast_rx_data);
                        end
                    end
                end
            end
            begin : slow_side
                #(real'(t0 - int'($time)) + 0.5);
                for (int k = 0; k < nper; k++) begin
                    if (k == 0) begin
                        check(slow_rx_data == '0, {note, " R7 slow receive reset state"}, slow_rx_data, 0);
                    end else begin
                        int sp;
                        int tp;
                        int exp_w;
                        sp = t0 + (k - 1) * q;
                        tp = ((sp + w + 3) / 4) * 4;
                        exp_w = (tp >= t0 + 8) ? (tp / 4) : 0;
                        check(slow_rx_data == W'(exp_w), {note, " R5 fast-to-slow word"},
                              slow_rx_data, exp_w);
                    end
                    slow_tx_data = W'(k + 1);
                    #(q);
                end
            end
        join
    endtask

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk_fast);
        for (int q = 8; q <= 21; q++) begin
            run_ratio(5'(q), q, 24, $sformatf("ratio %0d/4", q));
        end
        run_ratio(5'd3, 8, 12, "R1 clamp low");
        run_ratio(5'd30, 21, 12, "R1 clamp high");
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule